// File: doc/BRIEF.md
# CEC Header Address Filter and Acknowledge Decision

This block sits behind the bit-level receiver of a consumer-electronics control bus. It looks at the first byte of each incoming frame, the header. That byte holds the sender's logical address in its upper nibble and the target's logical address in its lower nibble. From the header the block decides three things: whether this device should take the frame, whether the frame was sent to everyone, and whether the device should pull the line for a positive acknowledge in the ack slot that follows each byte.

The device may own several logical addresses at once. These are given as a 15-bit mask, where bit `n` set means address `n` belongs to this device. Address 15 is the broadcast address and has no bit in the mask. A listen-all input selects the mode. In the narrow mode, frames for other devices are dropped. In the listen-all mode they are taken silently and never acknowledged. Broadcast frames are always taken and are never acknowledged. The decisions are captured when the header strobe arrives and are held until the frame-end or the next frame-start strobe.

Top module: `cec_hdr_filter`

## Requirements
- R1: After a synchronous active-low reset, `accept`, `ack_drive` and `bcast` are all 0.
- R2: When the target nibble `hdr_byte[3:0]` is below 15 and `own_mask[target]` is 1, `accept` is 1 and `bcast` is 0 from the cycle after the header strobe, and `ack_drive` is 1 in the cycle after each `ack_slot` strobe of that frame.
- R3: With `listen_all` = 0, a header whose target is below 15 and whose mask bit is 0 leaves `accept`, `bcast` and `ack_drive` at 0 for the whole frame.
- R4: A target nibble of 15 (broadcast) sets `bcast` and `accept` to 1 in the cycle after the header strobe, for any mask and any mode, and `ack_drive` stays 0 in every ack slot.
- R5: With `listen_all` = 1, a header for an unowned target below 15 sets `accept` to 1, while `bcast` and `ack_drive` stay 0.
- R6: The sender nibble `hdr_byte[7:4]` has no effect on any output.
- R7: Once decided, the outputs hold until a frame-end or frame-start strobe, and they read 0 in the cycle after it. Changes to `own_mask` or `listen_all` after the header strobe have no effect on the current frame.
- R8: Only the first header strobe after a frame-start is used. A header strobe with no frame open, or a second one in the same frame, changes no output.
- R9: `ack_drive` is 1 only in the cycle right after an `ack_slot` strobe. An ack slot in the same cycle as the header strobe, or in the same cycle as a frame-end, gives no acknowledge.
- R10: A frame-start strobe during an open frame drops the earlier decisions. The outputs read 0 until the new header is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe: a new frame begins |
| frame_end | input | 1 | One-cycle strobe: the current frame is over |
| hdr_valid | input | 1 | One-cycle strobe: `hdr_byte` holds a complete received byte |
| hdr_byte | input | 8 | Received byte; sender in [7:4], target in [3:0] |
| ack_slot | input | 1 | One-cycle strobe at the ack slot of each byte |
| own_mask | input | 15 | Owned logical addresses, bit n for address n |
| listen_all | input | 1 | 1 = also take frames for other devices, without acknowledge |
| accept | output | 1 | The current frame is to be received |
| ack_drive | output | 1 | Drive a positive acknowledge now |
| bcast | output | 1 | The current frame is a broadcast |

## Verification
The bench builds the block with its default 4-bit logical addresses, so there are 16 targets and a 15-bit mask. At that size the bench can run every target against every one-hot mask, the empty mask, the full mask and a few mixed masks, in both listening modes. The sender nibble is changed from frame to frame. This covers every mask bit, including the boundary between bit 14 and the broadcast address 15. Separate directed frames cover the corner cases: stray and repeated header strobes, configuration changes in the middle of a frame, a restart during a frame, and an ack slot that falls in the same cycle as the header strobe or the frame end.

// File: rtl/cec_hdr_pkg.sv
// Package: shared types and helpers for the CEC header filter.
// It assumes a header splits into two equal address nibbles.
package cec_hdr_pkg;

    // Decision captured from one header byte
    typedef struct packed {
        logic accept;   // frame is to be received
        logic own;      // target is one of this device's addresses
        logic bcast;    // target is the broadcast address
    } hdr_decision_t;

    localparam hdr_decision_t DECISION_NONE = '{accept: 1'b0, own: 1'b0, bcast: 1'b0};

endpackage

// File: rtl/cec_addr_match.sv
// Module: cec_addr_match
// Compares the target nibble against every bit of the owned-address
// mask. The highest address value is broadcast and has no mask bit.
// Purely combinational. It assumes the mask width is 2**ADDR_W - 1.
module cec_addr_match #(
    parameter int ADDR_W = 4,
    localparam int MASK_W = (1 << ADDR_W) - 1
) (
    input  logic [ADDR_W-1:0] target,
    input  logic [MASK_W-1:0] own_mask,
    output logic              own_hit,
    output logic              is_bcast
);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = ADDR_W'(MASK_W);

    logic [MASK_W-1:0] hit_vec;

    // One comparator per owned-address bit
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign hit_vec[i] = own_mask[i] && (target == ADDR_W'(i));
    end

    // Reduce the per-bit hits; the broadcast value never matches any bit
    always_comb begin
        own_hit  = |hit_vec;
        is_bcast = (target == BCAST_ADDR);
    end
endmodule

// File: rtl/cec_hdr_decode.sv
// Module: cec_hdr_decode
// Splits the header into sender and target, and forms the frame
// decision from the address match and the listening mode.
// Combinational. The sender nibble is left unused on purpose.
module cec_hdr_decode
    import cec_hdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int MASK_W = (1 << ADDR_W) - 1,
    localparam int HDR_W  = 2 * ADDR_W
) (
    input  logic [HDR_W-1:0]  hdr_byte,
    input  logic [MASK_W-1:0] own_mask,
    input  logic              listen_all,
    output hdr_decision_t     decision
);
    logic [ADDR_W-1:0] target;
    logic              own_hit;
    logic              is_bcast;

    // The target occupies the low nibble of the header
    assign target = hdr_byte[ADDR_W-1:0];

    cec_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .target   (target),
        .own_mask (own_mask),
        .own_hit  (own_hit),
        .is_bcast (is_bcast)
    );

    // Take the frame if it is owned, broadcast, or listen-all is set
    always_comb begin
        decision.bcast  = is_bcast;
        decision.own    = own_hit && !is_bcast;
        decision.accept = own_hit || is_bcast || listen_all;
    end
endmodule

// File: rtl/cec_frame_ctl.sv
// Module: cec_frame_ctl
// Tracks whether a frame is open and whether its header has been
// taken yet. It makes the capture and clear pulses for the decision
// register. Frame-start and frame-end both clear, and a header
// strobe in the same cycle as either one is not used.
module cec_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_end,
    input  logic hdr_valid,
    output logic take_hdr,
    output logic clear_now
);
    logic open_q;
    logic hdr_seen_q;

    // Clear on any frame boundary; capture only the first header of an open frame
    always_comb begin
        clear_now = frame_start || frame_end;
        take_hdr  = hdr_valid && open_q && !hdr_seen_q && !clear_now;
    end

    // Frame-open flag: start opens a frame (also over an open one), end closes it
    always_ff @(posedge clk) begin
        if (!rst_n)           open_q <= 1'b0;
        else if (frame_start) open_q <= 1'b1;
        else if (frame_end)   open_q <= 1'b0;
    end

    // Header-seen flag: set on the first capture, reset at every boundary
    always_ff @(posedge clk) begin
        if (!rst_n)         hdr_seen_q <= 1'b0;
        else if (clear_now) hdr_seen_q <= 1'b0;
        else if (take_hdr)  hdr_seen_q <= 1'b1;
    end
endmodule

// File: rtl/cec_ack_gen.sv
// Module: cec_ack_gen
// Produces the one-cycle acknowledge drive after each ack-slot strobe,
// only while the held decision says the frame is owned. It assumes the
// held decision is already cleared by the boundary that ends the frame.
module cec_ack_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_slot,
    input  logic own_held,
    input  logic clear_now,
    output logic ack_drive
);
    // Register the acknowledge request; no ack in a boundary cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ack_drive <= 1'b0;
        else        ack_drive <= ack_slot && own_held && !clear_now;
    end
endmodule

// File: rtl/cec_hdr_filter.sv
// Module: cec_hdr_filter (top)
// Header address filter and acknowledge decision for a CEC receiver.
// It captures the accept, own and broadcast decisions on the first header
// strobe of a frame and holds them to the frame boundary. It drives the
// acknowledge after each ack slot of an owned frame. It assumes strobes
// are single-cycle and synchronous to clk.
module cec_hdr_filter
    import cec_hdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int MASK_W = (1 << ADDR_W) - 1,
    localparam int HDR_W  = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              hdr_valid,
    input  logic [HDR_W-1:0]  hdr_byte,
    input  logic              ack_slot,
    input  logic [MASK_W-1:0] own_mask,
    input  logic              listen_all,
    output logic              accept,
    output logic              ack_drive,
    output logic              bcast
);
    hdr_decision_t dec_now;
    hdr_decision_t dec_q;
    logic          take_hdr;
    logic          clear_now;

    cec_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .hdr_valid   (hdr_valid),
        .take_hdr    (take_hdr),
        .clear_now   (clear_now)
    );

    cec_hdr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .hdr_byte   (hdr_byte),
        .own_mask   (own_mask),
        .listen_all (listen_all),
        .decision   (dec_now)
    );

    // Decision register: clear at boundaries, capture on the first header
    always_ff @(posedge clk) begin
        if (!rst_n)         dec_q <= DECISION_NONE;
        else if (clear_now) dec_q <= DECISION_NONE;
        else if (take_hdr)  dec_q <= dec_now;
    end

    cec_ack_gen u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_slot  (ack_slot),
        .own_held  (dec_q.own),
        .clear_now (clear_now),
        .ack_drive (ack_drive)
    );

    // Expose the held decision
    assign accept = dec_q.accept;
    assign bcast  = dec_q.bcast;
endmodule

// File: rtl/cec_hdr_filter_chk.sv
// Module: cec_hdr_filter_chk
// Port-level properties of the header filter, bound to the top module.
module cec_hdr_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic frame_end,
    input logic hdr_valid,
    input logic ack_slot,
    input logic accept,
    input logic ack_drive,
    input logic bcast
);
    // R4
    bcast_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast |-> accept);

    // R4
    no_ack_on_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast && ack_slot && !frame_start && !frame_end) |=> !ack_drive);

    // R9
    ack_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> ($past(ack_slot) && $past(accept)));

    // R7
    clear_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || frame_end) |=> (!accept && !bcast && !ack_drive));

    // R7
    hold_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !frame_start && !frame_end) |=> (accept && $stable(bcast)));

    // R8
    rise_needs_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> $past(hdr_valid));
endmodule

bind cec_hdr_filter cec_hdr_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .hdr_valid   (hdr_valid),
    .ack_slot    (ack_slot),
    .accept      (accept),
    .ack_drive   (ack_drive),
    .bcast       (bcast)
);

// File: tb/cec_hdr_filter_tb.sv
module cec_hdr_filter_tb;
    localparam int ADDR_W = 4;
    localparam int MASK_W = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              frame_end = 1'b0;
    logic              hdr_valid = 1'b0;
    logic [7:0]        hdr_byte = 8'h00;
    logic              ack_slot = 1'b0;
    logic [MASK_W-1:0] own_mask = '0;
    logic              listen_all = 1'b0;
    logic              accept, ack_drive, bcast;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cec_hdr_filter #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .hdr_valid(hdr_valid), .hdr_byte(hdr_byte), .ack_slot(ack_slot),
        .own_mask(own_mask), .listen_all(listen_all),
        .accept(accept), .ack_drive(ack_drive), .bcast(bcast)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic strobe_start();
        frame_start = 1'b1; step(); frame_start = 1'b0;
    endtask

    task automatic strobe_end();
        frame_end = 1'b1; step(); frame_end = 1'b0;
    endtask

    task automatic strobe_hdr(input logic [7:0] h);
        hdr_byte = h; hdr_valid = 1'b1; step(); hdr_valid = 1'b0;
    endtask

    task automatic strobe_ack();
        ack_slot = 1'b1; step(); ack_slot = 1'b0;
    endtask

    // Full frame: header plus two payload ack slots, checked against arithmetic expectations
    task automatic run_frame(input logic mode, input logic [MASK_W-1:0] m, input logic [7:0] h);
        logic [3:0] tgt;
        logic e_b, e_own, e_acc;
        tgt   = h[3:0];
        e_b   = (tgt == 4'd15);
        e_own = !e_b && m[tgt];
        e_acc = e_b || e_own || mode;
        own_mask = m; listen_all = mode;
        strobe_start();
        strobe_hdr(h);
        chk(e_b ? "R4 accept" : (e_own ? "R2 accept" : (mode ? "R5 accept" : "R3 accept")), accept, e_acc);
        chk("R4 bcast R6", bcast, e_b);
        strobe_ack();
        chk(e_own ? "R2 ack" : "R3 R4 R5 no ack", ack_drive, e_own);
        step();
        chk("R9 ack one cycle", ack_drive, 1'b0);
        strobe_ack();
        chk("R2 payload ack", ack_drive, e_own);
        chk("R7 hold accept", accept, e_acc);
        strobe_end();
        chk("R7 clear accept", accept, 1'b0);
        chk("R7 clear bcast", bcast, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [MASK_W-1:0] masks [20];
        repeat (3) step();
        chk("R1 accept", accept, 1'b0);
        chk("R1 ack", ack_drive, 1'b0);
        chk("R1 bcast", bcast, 1'b0);
        rst_n = 1'b1;
        step();

        for (int k = 0; k < MASK_W; k++) masks[k] = MASK_W'(1) << k;
        masks[15] = '0;
        masks[16] = '1;
        masks[17] = 15'h5555;
        masks[18] = 15'h2AAA;
        masks[19] = 15'h4081;

        // Sweep: both modes, all masks, all targets, varying sender nibble
        for (int md = 0; md < 2; md++)
            for (int mi = 0; mi < 20; mi++)
                for (int t = 0; t < 16; t++)
                    run_frame(md[0], masks[mi], {4'((t * 7 + mi + md) & 15), 4'(t)});

        // R8: header strobe with no frame open is ignored
        own_mask = '1; listen_all = 1'b1;
        strobe_hdr(8'h03);
        chk("R8 stray header", accept, 1'b0);

        // R8: second header in a frame is ignored
        listen_all = 1'b0; own_mask = 15'h0001;
        strobe_start();
        strobe_hdr(8'h45);
        chk("R8 first header unowned", accept, 1'b0);
        strobe_hdr(8'h40);
        chk("R8 second header ignored", accept, 1'b0);
        strobe_ack();
        chk("R8 no ack", ack_drive, 1'b0);
        strobe_end();

        // R7: configuration change after the header has no effect
        own_mask = 15'h0004; listen_all = 1'b0;
        strobe_start();
        strobe_hdr(8'h12);
        own_mask = '0; listen_all = 1'b1;
        step();
        chk("R7 accept kept", accept, 1'b1);
        strobe_ack();
        chk("R7 ack kept", ack_drive, 1'b1);
        strobe_end();
        own_mask = '0; listen_all = 1'b1;
        strobe_start();
        strobe_hdr(8'h17);
        listen_all = 1'b0; own_mask = 15'h0080;
        strobe_ack();
        chk("R7 no late ack", ack_drive, 1'b0);
        chk("R7 listen kept", accept, 1'b1);
        strobe_end();

        // R9: ack slot together with header strobe gives no ack
        own_mask = 15'h0008; listen_all = 1'b0;
        strobe_start();
        hdr_byte = 8'h03; hdr_valid = 1'b1; ack_slot = 1'b1; step();
        hdr_valid = 1'b0; ack_slot = 1'b0;
        chk("R9 ack same cycle as header", ack_drive, 1'b0);
        chk("R9 accept decided", accept, 1'b1);
        // R9: ack slot together with frame end gives no ack
        frame_end = 1'b1; ack_slot = 1'b1; step();
        frame_end = 1'b0; ack_slot = 1'b0;
        chk("R9 ack same cycle as end", ack_drive, 1'b0);
        chk("R7 end clears", accept, 1'b0);

        // R10: restart during an open frame drops the decision
        own_mask = '0; listen_all = 1'b0;
        strobe_start();
        strobe_hdr(8'h2F);
        chk("R10 bcast before restart", bcast, 1'b1);
        strobe_start();
        chk("R10 accept cleared", accept, 1'b0);
        chk("R10 bcast cleared", bcast, 1'b0);
        strobe_ack();
        chk("R10 no ack before header", ack_drive, 1'b0);
        strobe_hdr(8'h2F);
        chk("R10 new header decided", bcast, 1'b1);
        strobe_end();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule